// File: doc/BRIEF.md
# Receive Frame Ring Writer

This block takes received Ethernet frames as a stream of 64-bit little-endian words and places each one as a linked record in a circular memory of 64-bit words. The ring limits are two programmable word addresses, `ring_base` and `ring_top`. Each record has three parts:

- a link header word, which points to the next record;
- a status word, which carries the frame size and the error flags;
- the payload words.

The error flags are computed upstream and arrive with the last beat of each frame. The block publishes its write pointer once a record is complete. Software consumes records and returns space by writing the link value of the record it has finished into the read-pointer register.

The controller is a three-state machine.

- **S_DATA**: accepts beats. The first beat goes two words past the write pointer, and later beats go to successive words with wrap. A beat that would enter unread space marks the frame as dropped.
- **DATA_TO_STATUS**: on a last beat that is stored, the machine moves to **S_STATUS**. A dropped frame instead takes **DATA_TO_DATA_DROP**: it stays in S_DATA and discards its partial record.
- **S_STATUS**: writes the status word. **STATUS_TO_HEADER** then follows unconditionally.
- **S_HEADER**: writes the header word and moves the write pointer in the same edge. **HEADER_TO_DATA** then returns to S_DATA.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `hw_wr_ptr` equals `ring_base`, `rx_ready` is 1 and `mem_we` is 0. The internal read pointer also starts at `ring_base`.
- R2: All addresses count 64-bit words. Stepping past `ring_top` continues at `ring_base`, so a record may straddle the ring end.
- R3: The header word sits at the record's first address. Its fields are:
  - bits [32+AW-1:32]: the next-link pointer;
  - bits [50:48]: the bytes-valid count;
  - bit 63: ownership, written as 0;
  - bits [31:0]: all zero, so they are never all ones.
- R4: The status word sits at the next address. Its fields are:
  - bits [13:0]: the frame size in bytes;
  - bits [19:14]: `rx_flags` bits 0..5, which are drop, runt, oversize, jabber, CRC error and jumbo;
  - bit 31: the valid bit, set to 1;
  - all other bits: 0.
- R5: Payload beat k is stored unchanged at record address + 2 + k, with ring wrap. Frame byte 0 is in bits [7:0].
- R6: The next-link value is the word after the last payload word. The bytes-valid count is the frame size mod 8.
- R7: The status word is written first and the header word second. `hw_wr_ptr` moves to the next-link value at the edge that writes the header.
- R8: Free space is (rd − wr − 1) mod ring size. A frame is kept only if 2 + beats ≤ free space. Otherwise it is dropped whole: `hw_wr_ptr` does not move, unread words are never written, and the write pointer never becomes equal to the read pointer through a publish.
- R9: Setting `cpu_rd_we` loads `cpu_rd_ptr` into the read pointer, which releases the space before it. Write-pointer equal to read-pointer means the ring is empty.
- R10: After the last beat of a stored frame, `rx_ready` is low for exactly two cycles. After a dropped frame, it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | AW | First word address of the ring |
| ring_top | input | AW | Last word address of the ring |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Block can take a beat |
| rx_data | input | 64 | Payload word, little-endian bytes |
| rx_last | input | 1 | Last beat of the frame |
| rx_size | input | SW | Frame size in bytes, valid with `rx_last` |
| rx_flags | input | 6 | Error flags, valid with `rx_last` |
| cpu_rd_we | input | 1 | Software read-pointer write strobe |
| cpu_rd_ptr | input | AW | Software read-pointer value |
| hw_wr_ptr | output | AW | Published write pointer |
| mem_we | output | 1 | Ring memory write enable |
| mem_addr | output | AW | Ring memory word address |
| mem_wdata | output | 64 | Ring memory write data |

## Verification
Several properties are checked on every cycle:
- the published pointer stays inside the ring;
- each pointer move is preceded by a header write at the old pointer, with the status write one cycle before that;
- a publish never lands on the read pointer;
- header words never carry an all-ones lower half;
- the ready stall after a stored frame lasts two cycles.

The record contents need the bench's scenarios: field placement, payload order across the ring end, the fill boundary where a record exactly uses the free space, a dropped frame that leaves unread data untouched, and space released by a read-pointer write.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [1:0] {
        S_DATA,
        S_STATUS,
        S_HEADER
    } rxr_state_e;

    localparam int FLAG_W        = 6;
    localparam int STS_FLAG_LSB  = 14;
    localparam int STS_VALID_BIT = 31;
    localparam int HDR_LINK_LSB  = 32;
    localparam int HDR_BV_LSB    = 48;
    localparam int HDR_OWN_BIT   = 63;
endpackage

// File: rtl/rxr_ring_step.sv
module rxr_ring_step #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] top,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // step one word, wrapping the top to the base
    always_comb begin
        nxt = (cur == top) ? base : cur + ONE;
    end
endmodule

// File: rtl/rxr_free_calc.sv
module rxr_free_calc #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] wr,
    input  logic [AW-1:0] rd,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] top,
    output logic [AW:0]   free_words
);
    localparam logic [AW:0] ONE = (AW+1)'(1);

    logic [AW:0] span;

    always_comb begin
        span = {1'b0, top} - {1'b0, base} + ONE;
        if (rd > wr)
            free_words = {1'b0, rd} - {1'b0, wr} - ONE;
        else
            free_words = span - ({1'b0, wr} - {1'b0, rd}) - ONE;
    end
endmodule

// File: rtl/rxr_word_fmt.sv
module rxr_word_fmt
    import rxr_pkg::*;
#(
    parameter int AW = 10,
    parameter int SW = 14
) (
    input  logic [AW-1:0]     next_link,
    input  logic [SW-1:0]     size,
    input  logic [FLAG_W-1:0] flags,
    output logic [63:0]       hdr_word,
    output logic [63:0]       sts_word
);
    always_comb begin
        hdr_word                    = '0;
        hdr_word[HDR_LINK_LSB +: AW] = next_link;
        hdr_word[HDR_BV_LSB +: 3]    = size[2:0];
        hdr_word[HDR_OWN_BIT]        = 1'b0;
    end

    always_comb begin
        sts_word                         = '0;
        sts_word[SW-1:0]                 = size;
        sts_word[STS_FLAG_LSB +: FLAG_W] = flags;
        sts_word[STS_VALID_BIT]          = 1'b1;
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW = 10,
    parameter int SW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ring_base,
    input  logic [AW-1:0]     ring_top,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [63:0]       rx_data,
    input  logic              rx_last,
    input  logic [SW-1:0]     rx_size,
    input  logic [FLAG_W-1:0] rx_flags,
    input  logic              cpu_rd_we,
    input  logic [AW-1:0]     cpu_rd_ptr,
    output logic [AW-1:0]     hw_wr_ptr,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [63:0]       mem_wdata
);
    localparam logic [AW:0] REC_HDR_WORDS = (AW+1)'(2);
    localparam logic [AW:0] ONE_W         = (AW+1)'(1);

    rxr_state_e        state_q, state_d;
    logic [AW-1:0]     wp_q, rp_q, pay_q;
    logic [AW:0]       rec_len_q;
    logic              drop_q;
    logic [SW-1:0]     size_q;
    logic [FLAG_W-1:0] flags_q;

    logic [AW-1:0]     wp1, wp2, wr_addr, wr_next;
    logic [AW:0]       free_words;
    logic [63:0]       hdr_word, sts_word;
    logic              beat, fits, store;

    rxr_ring_step #(.AW(AW)) u_step_wp1 (.cur(wp_q),    .base(ring_base), .top(ring_top), .nxt(wp1));
    rxr_ring_step #(.AW(AW)) u_step_wp2 (.cur(wp1),     .base(ring_base), .top(ring_top), .nxt(wp2));
    rxr_ring_step #(.AW(AW)) u_step_pay (.cur(wr_addr), .base(ring_base), .top(ring_top), .nxt(wr_next));

    rxr_free_calc #(.AW(AW)) u_free (
        .wr(wp_q), .rd(rp_q), .base(ring_base), .top(ring_top), .free_words(free_words)
    );

    rxr_word_fmt #(.AW(AW), .SW(SW)) u_fmt (
        .next_link(pay_q), .size(size_q), .flags(flags_q),
        .hdr_word(hdr_word), .sts_word(sts_word)
    );

    // first payload word of a record sits two words past the pointer
    assign wr_addr = (rec_len_q == REC_HDR_WORDS) ? wp2 : pay_q;
    assign beat    = (state_q == S_DATA) && rx_valid;
    assign fits    = (rec_len_q + ONE_W) <= free_words;
    assign store   = beat && !drop_q && fits;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_DATA;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_DATA:   if (store && rx_last) state_d = S_STATUS;
            S_STATUS: state_d = S_HEADER;
            S_HEADER: state_d = S_DATA;
            default:  state_d = S_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q      <= ring_base;
            rp_q      <= ring_base;
            pay_q     <= ring_base;
            rec_len_q <= REC_HDR_WORDS;
            drop_q    <= 1'b0;
            size_q    <= '0;
            flags_q   <= '0;
        end else begin
            if (cpu_rd_we) rp_q <= cpu_rd_ptr;
            unique case (state_q)
                S_DATA: begin
                    if (beat) begin
                        if (store) begin
                            pay_q     <= wr_next;
                            rec_len_q <= rec_len_q + ONE_W;
                        end
                        if (rx_last) begin
                            if (store) begin
                                size_q  <= rx_size;
                                flags_q <= rx_flags;
                            end else begin
                                drop_q    <= 1'b0;
                                rec_len_q <= REC_HDR_WORDS;
                            end
                        end else if (!store) begin
                            drop_q <= 1'b1;
                        end
                    end
                end
                S_HEADER: begin
                    wp_q      <= pay_q;
                    rec_len_q <= REC_HDR_WORDS;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rx_ready  = (state_q == S_DATA);
        mem_we    = 1'b0;
        mem_addr  = wr_addr;
        mem_wdata = rx_data;
        unique case (state_q)
            S_DATA:   mem_we = store;
            S_STATUS: begin mem_we = 1'b1; mem_addr = wp1;  mem_wdata = sts_word; end
            S_HEADER: begin mem_we = 1'b1; mem_addr = wp_q; mem_wdata = hdr_word; end
            default:  mem_we = 1'b0;
        endcase
    end

    assign hw_wr_ptr = wp_q;

    p_ptr_in_ring_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_base <= ring_top) |-> (hw_wr_ptr >= ring_base && hw_wr_ptr <= ring_top));

    p_hdr_before_publish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_wr_ptr != $past(hw_wr_ptr)) |-> ($past(mem_we) && $past(mem_addr) == $past(hw_wr_ptr)));

    p_status_then_hdr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !rx_ready && mem_addr == hw_wr_ptr) |-> ($past(mem_we) && !$past(rx_ready)));

    p_no_false_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_wr_ptr != $past(hw_wr_ptr)) |-> (hw_wr_ptr != $past(rp_q)));

    p_hdr_low_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !rx_ready && mem_addr == hw_wr_ptr) |-> (mem_wdata[31:0] != 32'hFFFF_FFFF));

    p_stall_two_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ready) |=> !rx_ready ##1 rx_ready);
endmodule

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
    localparam int CLK_P = 10;
    localparam int AW    = 10;
    localparam int SW    = 14;
    localparam int BASE  = 16;
    localparam int TOP   = 47;
    localparam int RSZ   = TOP - BASE + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ring_base = AW'(BASE);
    logic [AW-1:0] ring_top  = AW'(TOP);
    logic          rx_valid = 1'b0, rx_ready, rx_last = 1'b0;
    logic [63:0]   rx_data = '0;
    logic [SW-1:0] rx_size = '0;
    logic [5:0]    rx_flags = '0;
    logic          cpu_rd_we = 1'b0;
    logic [AW-1:0] cpu_rd_ptr = '0;
    logic [AW-1:0] hw_wr_ptr;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;

    logic [63:0] mem [0:(1<<AW)-1];

    int checks = 0, failures = 0;
    int m_wp = BASE, m_rd = BASE;
    int rec_start_q[$], rec_next_q[$], rec_n_q[$];
    int addr_q[$];
    logic [63:0] word_q[$];
    bit mon_en = 1'b0;
    int last_wp = BASE;

    always #(CLK_P/2) clk = ~clk;

    rx_ring_writer #(.AW(AW), .SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_top(ring_top),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
        .rx_size(rx_size), .rx_flags(rx_flags), .cpu_rd_we(cpu_rd_we), .cpu_rd_ptr(cpu_rd_ptr),
        .hw_wr_ptr(hw_wr_ptr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int inc(input int a);
        return (a == TOP) ? BASE : a + 1;
    endfunction

    // scoreboard monitor: on each publish pop the expected record and compare memory
    always @(negedge clk) begin
        if (mon_en && int'(hw_wr_ptr) != last_wp) begin
            if (rec_start_q.size() == 0) begin
                chk(1'b0, "R8 unexpected publish", 64'(hw_wr_ptr), 64'(last_wp));
            end else begin
                int st, nx, n;
                st = rec_start_q.pop_front();
                nx = rec_next_q.pop_front();
                n  = rec_n_q.pop_front();
                chk(st == last_wp, "R7 record start", 64'(last_wp), 64'(st));
                chk(int'(hw_wr_ptr) == nx, "R6 next link published", 64'(hw_wr_ptr), 64'(nx));
                for (int i = 0; i < n; i++) begin
                    int a;
                    logic [63:0] w;
                    a = addr_q.pop_front();
                    w = word_q.pop_front();
                    chk(mem[a] === w, (i == 0) ? "R3 header word" : (i == 1) ? "R4 status word" : "R5 payload word", mem[a], w);
                end
            end
            last_wp = int'(hw_wr_ptr);
        end
    end

    task automatic send_frame(input int nb, input int sz, input logic [5:0] fl, input int seed);
        int free, a, p;
        bit accept;
        logic [63:0] hdr, sts, pw;
        bit r0, r1, r2;
        free   = (m_rd - m_wp - 1 + RSZ) % RSZ;
        accept = (nb + 2) <= free;
        if (accept) begin
            a = m_wp;
            p = inc(inc(a));
            for (int i = 0; i < nb; i++) p = inc(p);
            hdr = '0; hdr[32 +: AW] = AW'(p); hdr[48 +: 3] = 3'(sz % 8);
            sts = '0; sts[13:0] = 14'(sz); sts[14 +: 6] = fl; sts[31] = 1'b1;
            rec_start_q.push_back(a); rec_next_q.push_back(p); rec_n_q.push_back(nb + 2);
            addr_q.push_back(a);      word_q.push_back(hdr);
            addr_q.push_back(inc(a)); word_q.push_back(sts);
            p = inc(inc(a));
            for (int i = 0; i < nb; i++) begin
                pw = {32'(seed * 7 + i), 32'(seed * 131 + i * 3)};
                addr_q.push_back(p); word_q.push_back(pw);
                p = inc(p);
            end
        end
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = {32'(seed * 7 + i), 32'(seed * 131 + i * 3)};
            rx_last  = (i == nb - 1);
            rx_size  = SW'(sz);
            rx_flags = fl;
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0; r0 = rx_ready;
        @(negedge clk); r1 = rx_ready;
        @(negedge clk); r2 = rx_ready;
        if (accept) chk(!r0 && !r1 && r2, "R10 two-cycle stall after stored frame", {r0, r1, r2}, 3'b001);
        else        chk(r0 && r1 && r2, "R10 no stall after dropped frame", {r0, r1, r2}, 3'b111);
        if (accept) m_wp = p;
        repeat (2) @(negedge clk);
        chk(int'(hw_wr_ptr) == m_wp, accept ? "R7 pointer after frame" : "R8 pointer held on drop", 64'(hw_wr_ptr), 64'(m_wp));
    endtask

    task automatic release_to(input int v);
        @(negedge clk); cpu_rd_we = 1'b1; cpu_rd_ptr = AW'(v);
        @(negedge clk); cpu_rd_we = 1'b0;
        m_rd = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] keep;
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(int'(hw_wr_ptr) == BASE, "R1 reset pointer", 64'(hw_wr_ptr), 64'(BASE));
        chk(rx_ready == 1'b1, "R1 reset ready", 64'(rx_ready), 1);
        chk(mem_we == 1'b0, "R1 no write after reset", 64'(mem_we), 0);
        mon_en = 1'b1;

        send_frame(1, 5, 6'b000000, 1);          // record 16..18
        send_frame(3, 24, 6'b010000, 2);         // CRC flag, 19..23
        release_to(24);                           // R9 release
        send_frame(5, 37, 6'b100010, 3);         // runt+jumbo, 24..30
        send_frame(8, 60, 6'b000001, 4);         // 31..40
        send_frame(6, 44, 6'b001100, 5);         // R2 wraps: 41..47,16
        keep = mem[24];
        send_frame(5, 40, 6'b000000, 6);         // R8 needs 7, free 6: dropped
        chk(mem[24] === keep, "R8 unread record untouched", mem[24], keep);
        send_frame(4, 32, 6'b000000, 7);         // R8 exactly fills free space
        release_to(23);                           // R9 ring now empty
        send_frame(1, 8, 6'b000100, 8);          // R9 accepted at 23
        repeat (4) @(negedge clk);
        chk(rec_start_q.size() == 0, "R7 all records published", 64'(rec_start_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule